// File: doc/BRIEF.md
# PLL Factor Update Sequencer

This block moves a PLL control register from its present N, K, M and P factors to new target factors without any overshoot in the output frequency. The output frequency is parent × N × K / (M × P). If all four fields are written at once, the hardware can apply the multiplier before the divider, so the clock can briefly run faster than both the old and the new setting. The sequencer avoids this by splitting the change into two read-modify-write operations with a programmable settle interval between them.

A requester presents target factors on a valid/ack handshake. The sequencer reads the register and decodes the old factors. It then compares the old and new total division M × P. If the division grows, it writes the divider group (M, P) first. Otherwise it writes the multiplier group (N, K) first. It then waits the settle interval and writes the other group. Every write keeps all register bits outside the updated fields. The factors are chosen elsewhere, and the PLL itself sits outside this block.

Top module: `pll_step_seq`

## Requirements
- R1: A request on `req_valid` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the ack cycle. The read, write and ack strobes occur only while `busy` is high, and never two in the same cycle.
- R2: In the first cycle after acceptance, `rd_en` is high for exactly one cycle, and `rd_data` is taken in that same cycle.
- R3: Field encoding with default parameters: M sits in bits [1:0], K in bits [5:4] and N in bits [12:8], each holding value minus 1. P sits in bits [17:16] and holds log2 of the divider. The old and new M × P products are compared without overflow, up to M = 4 and P = 8.
- R4: When the new M × P is greater than the old one, the first write changes only the M and P fields to their new codes.
- R5: When the new M × P is less than or equal to the old one, the first write changes only the N and K fields to their new codes.
- R6: The second write holds the new codes in all four fields. After it, the register holds the target factors.
- R7: Both writes keep every register bit outside N, K, M and P equal to the value read.
- R8: With a settle count S, the second write comes max(S,1)+1 cycles after the first write.
- R9: If the target factors equal the decoded old factors, no write is made, and `req_ack` is high in the second cycle after acceptance.
- R10: `req_ack` is high for exactly one cycle, the cycle after the second write. Changes on the request inputs while busy have no effect on the sequence in progress.
- R11: A synchronous active-low reset in the middle of a sequence returns the block to idle with no strobes active in the next cycle. A later request then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Update request, held until ack |
| req_n | input | N_W+1 | Target N value |
| req_k | input | K_W+1 | Target K value |
| req_m | input | M_W+1 | Target M value |
| req_plog | input | P_W | Target P as log2 |
| settle_cycles | input | CNT_W | Settle interval in cycles between the two writes |
| req_ack | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| rd_en | output | 1 | Register read strobe (data valid in the same cycle) |
| rd_data | input | REG_W | Current register contents |
| wr_en | output | 1 | Register write strobe |
| wr_data | output | REG_W | Register write value |

## Verification
Counting from the clock edge that accepts the request, the bench expects these events: the read strobe one cycle later, the first write two cycles later, the second write max(S,1)+3 cycles later, and the ack one cycle after that. When nothing changes, the ack comes two cycles after acceptance. The bench drives inputs and samples every strobe on the falling edge. It logs the cycle index of each event, so each result is compared against its expected cycle rather than polled for. It also checks that the ack has dropped one cycle after it rose.

// File: rtl/pll_step_pkg.sv
// Shared types and helpers for the PLL factor update sequencer.
// Assumes field positions fit within 64 bits.
package pll_step_pkg;

    // Sequencer states, one per phase of the two-step update
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE1,
        ST_WAIT,
        ST_WRITE2,
        ST_DONE
    } seq_state_t;

    // Bit mask covering a field of width w at position sh
    function automatic logic [63:0] field_span(input int unsigned sh, input int unsigned w);
        return ((64'd1 << w) - 64'd1) << sh;
    endfunction

endpackage

// File: rtl/pll_field_slot.sv
// One factor field: encodes a target value into its stored code
// (value minus offset), places it at its register position and
// reports whether the code differs from the current code.
// Assumes the target lies inside the field's representable range.
module pll_field_slot #(
    parameter int REG_W = 32,
    parameter int SH    = 0,
    parameter int W     = 2,
    parameter int OFF   = 1
) (
    input  logic [W-1:0]     cur_code,
    input  logic [W:0]       tgt_val,
    output logic [REG_W-1:0] placed,
    output logic             changed
);
    logic [W-1:0] tgt_code;

    // Encode the target and compare with the stored code
    always_comb begin
        tgt_code = W'(tgt_val - (W+1)'(OFF));
        placed   = REG_W'(tgt_code) << SH;
        changed  = (tgt_code != cur_code);
    end
endmodule

// File: rtl/pll_factor_codec.sv
// Decodes the old M and P from a register image and builds the
// three candidate write images: new N/K only, new M/P only, and all
// four. Bits outside the four fields pass through untouched.
// Assumes the four fields do not overlap.
module pll_factor_codec #(
    parameter int REG_W = 32,
    parameter int N_SH = 8,  parameter int N_W = 5, parameter int N_OFF = 1,
    parameter int K_SH = 4,  parameter int K_W = 2, parameter int K_OFF = 1,
    parameter int M_SH = 0,  parameter int M_W = 2, parameter int M_OFF = 1,
    parameter int P_SH = 16, parameter int P_W = 2
) (
    input  logic [REG_W-1:0] cur_reg,
    input  logic [N_W:0]     tgt_n,
    input  logic [K_W:0]     tgt_k,
    input  logic [M_W:0]     tgt_m,
    input  logic [P_W-1:0]   tgt_plog,
    output logic [M_W:0]     old_m,
    output logic [P_W-1:0]   old_plog,
    output logic [REG_W-1:0] mul_image,
    output logic [REG_W-1:0] div_image,
    output logic [REG_W-1:0] full_image,
    output logic             unchanged
);
    import pll_step_pkg::*;

    localparam logic [REG_W-1:0] N_MASK  = REG_W'(field_span(N_SH, N_W));
    localparam logic [REG_W-1:0] K_MASK  = REG_W'(field_span(K_SH, K_W));
    localparam logic [REG_W-1:0] M_MASK  = REG_W'(field_span(M_SH, M_W));
    localparam logic [REG_W-1:0] P_MASK  = REG_W'(field_span(P_SH, P_W));
    localparam logic [REG_W-1:0] MUL_GRP = N_MASK | K_MASK;
    localparam logic [REG_W-1:0] DIV_GRP = M_MASK | P_MASK;

    logic [REG_W-1:0] n_pl, k_pl, m_pl, p_pl;
    logic             n_ch, k_ch, m_ch, p_ch;

    pll_field_slot #(.REG_W(REG_W), .SH(N_SH), .W(N_W), .OFF(N_OFF)) u_n (
        .cur_code(cur_reg[N_SH +: N_W]), .tgt_val(tgt_n), .placed(n_pl), .changed(n_ch));
    pll_field_slot #(.REG_W(REG_W), .SH(K_SH), .W(K_W), .OFF(K_OFF)) u_k (
        .cur_code(cur_reg[K_SH +: K_W]), .tgt_val(tgt_k), .placed(k_pl), .changed(k_ch));
    pll_field_slot #(.REG_W(REG_W), .SH(M_SH), .W(M_W), .OFF(M_OFF)) u_m (
        .cur_code(cur_reg[M_SH +: M_W]), .tgt_val(tgt_m), .placed(m_pl), .changed(m_ch));
    pll_field_slot #(.REG_W(REG_W), .SH(P_SH), .W(P_W), .OFF(0)) u_p (
        .cur_code(cur_reg[P_SH +: P_W]), .tgt_val({1'b0, tgt_plog}), .placed(p_pl), .changed(p_ch));

    // Recover the old divider factors from the stored codes
    always_comb begin
        old_m    = (M_W+1)'(cur_reg[M_SH +: M_W]) + (M_W+1)'(M_OFF);
        old_plog = cur_reg[P_SH +: P_W];
    end

    // Merge new field codes into the current image per group
    always_comb begin
        mul_image  = (cur_reg & ~MUL_GRP) | n_pl | k_pl;
        div_image  = (cur_reg & ~DIV_GRP) | m_pl | p_pl;
        full_image = (cur_reg & ~(MUL_GRP | DIV_GRP)) | n_pl | k_pl | m_pl | p_pl;
        unchanged  = !(n_ch || k_ch || m_ch || p_ch);
    end
endmodule

// File: rtl/pll_mp_compare.sv
// Compares the total division M x P of the old and new settings.
// P is given as log2, so each product is M shifted left by log2 P.
// The product width holds the largest M times the largest P exactly.
module pll_mp_compare #(
    parameter int M_VW = 3,
    parameter int P_W  = 2
) (
    input  logic [M_VW-1:0] old_m,
    input  logic [P_W-1:0]  old_plog,
    input  logic [M_VW-1:0] new_m,
    input  logic [P_W-1:0]  new_plog,
    output logic            div_grows
);
    localparam int MP_W = M_VW + (1 << P_W) - 1;

    logic [MP_W-1:0] old_mp, new_mp;

    // Form both products and decide whether the division grows
    always_comb begin
        old_mp    = MP_W'(old_m) << old_plog;
        new_mp    = MP_W'(new_m) << new_plog;
        div_grows = (new_mp > old_mp);
    end
endmodule

// File: rtl/pll_settle_timer.sv
// Down-counter for the settle interval between the two writes.
// Loaded with the programmed count, it reports done once the count
// is at or below one, so the wait lasts max(count,1) cycles.
module pll_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on request, count down while the wait is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && !done) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expiry flag
    assign done = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/pll_step_seq.sv
// PLL factor update sequencer top. It accepts target factors, reads
// the register, and then applies the factors in two read-modify-write
// steps ordered so the output never overshoots. A settle wait sits
// between the steps.
// Assumes: rd_data is valid in the same cycle as rd_en. The register
// changes only through wr_en while the sequence is running. The
// requester holds req_valid until req_ack.
module pll_step_seq #(
    parameter int REG_W = 32,
    parameter int N_SH = 8,  parameter int N_W = 5, parameter int N_OFF = 1,
    parameter int K_SH = 4,  parameter int K_W = 2, parameter int K_OFF = 1,
    parameter int M_SH = 0,  parameter int M_W = 2, parameter int M_OFF = 1,
    parameter int P_SH = 16, parameter int P_W = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [N_W:0]     req_n,
    input  logic [K_W:0]     req_k,
    input  logic [M_W:0]     req_m,
    input  logic [P_W-1:0]   req_plog,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             req_ack,
    output logic             busy,
    output logic             rd_en,
    input  logic [REG_W-1:0] rd_data,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data
);
    import pll_step_pkg::*;

    localparam int M_VW = M_W + 1;

    seq_state_t       state_q, state_d;
    logic [N_W:0]     tgt_n_q;
    logic [K_W:0]     tgt_k_q;
    logic [M_W:0]     tgt_m_q;
    logic [P_W-1:0]   tgt_p_q;
    logic [REG_W-1:0] image_q, src_image;
    logic             div_first_q;
    logic [M_W:0]     old_m;
    logic [P_W-1:0]   old_plog;
    logic [REG_W-1:0] mul_img, div_img, full_img;
    logic             unchanged, div_grows, settle_done;

    // Decode from the live read during READ, else from the held image
    assign src_image = (state_q == ST_READ) ? rd_data : image_q;

    pll_factor_codec #(
        .REG_W(REG_W),
        .N_SH(N_SH), .N_W(N_W), .N_OFF(N_OFF),
        .K_SH(K_SH), .K_W(K_W), .K_OFF(K_OFF),
        .M_SH(M_SH), .M_W(M_W), .M_OFF(M_OFF),
        .P_SH(P_SH), .P_W(P_W)
    ) u_codec (
        .cur_reg   (src_image),
        .tgt_n     (tgt_n_q),
        .tgt_k     (tgt_k_q),
        .tgt_m     (tgt_m_q),
        .tgt_plog  (tgt_p_q),
        .old_m     (old_m),
        .old_plog  (old_plog),
        .mul_image (mul_img),
        .div_image (div_img),
        .full_image(full_img),
        .unchanged (unchanged)
    );

    pll_mp_compare #(.M_VW(M_VW), .P_W(P_W)) u_cmp (
        .old_m    (old_m),
        .old_plog (old_plog),
        .new_m    (tgt_m_q),
        .new_plog (tgt_p_q),
        .div_grows(div_grows)
    );

    pll_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_WRITE1),
        .load_val(settle_cycles),
        .run     (state_q == ST_WAIT),
        .done    (settle_done)
    );

    // Next-state selection for the update sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_READ;
            ST_READ:   state_d = unchanged ? ST_DONE : ST_WRITE1;
            ST_WRITE1: state_d = ST_WAIT;
            ST_WAIT:   if (settle_done) state_d = ST_WRITE2;
            ST_WRITE2: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, latched targets, register image and chosen order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tgt_n_q     <= '0;
            tgt_k_q     <= '0;
            tgt_m_q     <= '0;
            tgt_p_q     <= '0;
            image_q     <= '0;
            div_first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                tgt_n_q <= req_n;
                tgt_k_q <= req_k;
                tgt_m_q <= req_m;
                tgt_p_q <= req_plog;
            end
            if (state_q == ST_READ) begin
                image_q     <= rd_data;
                div_first_q <= div_grows;
            end
        end
    end

    // Register port drive: first group, then the full image
    always_comb begin
        wr_en   = 1'b0;
        wr_data = image_q;
        unique case (state_q)
            ST_WRITE1: begin
                wr_en   = 1'b1;
                wr_data = div_first_q ? div_img : mul_img;
            end
            ST_WRITE2: begin
                wr_en   = 1'b1;
                wr_data = full_img;
            end
            default: ;
        endcase
    end

    // Handshake and status outputs
    assign rd_en   = (state_q == ST_READ);
    assign req_ack = (state_q == ST_DONE);
    assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/pll_step_seq_chk.sv
// Property checker for the sequencer, attached by bind. It watches
// the ports only and keeps its own copy of the value read and its
// own gap counter between the two writes.
module pll_step_seq_chk #(
    parameter int REG_W = 32,
    parameter int N_SH = 8,  parameter int N_W = 5,
    parameter int K_SH = 4,  parameter int K_W = 2,
    parameter int M_SH = 0,  parameter int M_W = 2,
    parameter int P_SH = 16, parameter int P_W = 2,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ack,
    input logic             busy,
    input logic             rd_en,
    input logic [REG_W-1:0] rd_data,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [CNT_W-1:0] settle_cycles
);
    import pll_step_pkg::*;

    localparam logic [REG_W-1:0] NK_MASK =
        REG_W'(field_span(N_SH, N_W) | field_span(K_SH, K_W));
    localparam logic [REG_W-1:0] MP_MASK =
        REG_W'(field_span(M_SH, M_W) | field_span(P_SH, P_W));
    localparam logic [REG_W-1:0] ALL_MASK = NK_MASK | MP_MASK;

    logic [REG_W-1:0] snap_q;
    logic             second_q;
    logic [CNT_W:0]   gap_q;

    // Capture the value read and track the write phase and gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q   <= '0;
            second_q <= 1'b0;
            gap_q    <= '0;
        end else begin
            if (rd_en) snap_q <= rd_data;
            if (wr_en) begin
                second_q <= !second_q;
                gap_q    <= '0;
            end else if (second_q && gap_q != '1) begin
                gap_q <= gap_q + (CNT_W+1)'(1);
            end
        end
    end

    assert_strobes_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en || req_ack) |-> busy);
    assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, wr_en, req_ack}));
    assert_read_then_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (wr_en || req_ack));
    assert_first_one_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !second_q) |->
            (((wr_data ^ snap_q) & NK_MASK) == '0 || ((wr_data ^ snap_q) & MP_MASK) == '0));
    assert_keep_other_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (((wr_data ^ snap_q) & ~ALL_MASK) == '0));
    assert_settle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && second_q) |-> (gap_q >= (CNT_W+1)'(settle_cycles)));
    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
endmodule

bind pll_step_seq pll_step_seq_chk #(
    .REG_W(REG_W),
    .N_SH(N_SH), .N_W(N_W),
    .K_SH(K_SH), .K_W(K_W),
    .M_SH(M_SH), .M_W(M_W),
    .P_SH(P_SH), .P_W(P_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ack      (req_ack),
    .busy         (busy),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .settle_cycles(settle_cycles)
);

// File: tb/pll_step_seq_test.sv
// Self-checking bench: a vector table walked by one loop, then directed
// reset, busy-change and abort tests. Acts as the register itself.
module pll_step_seq_test;

    typedef struct packed {
        logic [5:0]  on; logic [2:0] ok; logic [2:0] om; logic [1:0] op;
        logic [5:0]  nn; logic [2:0] nk; logic [2:0] nm; logic [1:0] np;
        logic [7:0]  settle;
        logic [31:0] spare;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'd10, 3'd2, 3'd2 - 3'd1, 2'd0, 6'd20, 3'd2, 3'd2, 2'd0, 8'd5, 32'h8000_0040},
        '{6'd12, 3'd3, 3'd2, 2'd1, 6'd16, 3'd3, 3'd1, 2'd0, 8'd3, 32'h0004_00C0},
        '{6'd8,  3'd1, 3'd2, 2'd1, 6'd9,  3'd1, 3'd4, 2'd0, 8'd0, 32'hFFFC_E0CC},
        '{6'd5,  3'd4, 3'd1, 2'd0, 6'd30, 3'd4, 3'd4, 2'd3, 8'd1, 32'h0000_0000},
        '{6'd16, 3'd2, 3'd3, 2'd2, 6'd24, 3'd2, 3'd3, 2'd2, 8'd2, 32'h8000_0040},
        '{6'd7,  3'd2, 3'd2, 2'd1, 6'd7,  3'd2, 3'd2, 2'd1, 8'd4, 32'h0004_00C0},
        '{6'd32, 3'd4, 3'd4, 2'd3, 6'd1,  3'd1, 3'd3, 2'd3, 8'd7, 32'hFFFC_E0CC},
        '{6'd20, 3'd2, 3'd3, 2'd0, 6'd20, 3'd2, 3'd1, 2'd2, 8'd4, 32'h0100_0000}
    };
    localparam logic [31:0] NK_MASK = 32'h0000_1F30;
    localparam logic [31:0] MP_MASK = 32'h0003_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_n = '0;
    logic [2:0]  req_k = '0;
    logic [2:0]  req_m = '0;
    logic [1:0]  req_plog = '0;
    logic [15:0] settle_cycles = '0;
    logic        req_ack, busy, rd_en, wr_en;
    logic [31:0] rd_data, wr_data;
    logic [31:0] reg_model = '0;
    logic [31:0] load_val = '0;
    logic        load_req = 1'b0;

    int checks = 0;
    int errors = 0;
    int rd_cyc, nwr, c1, c2, ack_cyc, busy1;
    logic [31:0] w1, w2;

    always #5 clk = ~clk;

    pll_step_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_n(req_n), .req_k(req_k), .req_m(req_m), .req_plog(req_plog),
        .settle_cycles(settle_cycles), .req_ack(req_ack), .busy(busy),
        .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data)
    );

    // The controlled register: preset by the bench, written by the block
    assign rd_data = reg_model;
    always @(posedge clk) begin
        if (load_req) reg_model <= load_val;
        else if (wr_en) reg_model <= wr_data;
    end

    function automatic logic [31:0] enc_nk(logic [5:0] n, logic [2:0] k);
        logic [4:0] nc = 5'(n - 6'd1);
        logic [1:0] kc = 2'(k - 3'd1);
        return (32'(nc) << 8) | (32'(kc) << 4);
    endfunction

    function automatic logic [31:0] enc_mp(logic [2:0] m, logic [1:0] p);
        logic [1:0] mc = 2'(m - 3'd1);
        return 32'(mc) | (32'(p) << 16);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request and log event cycles; optional change of inputs at chg_at
    task automatic run_seq(input vec_t v, input int chg_at);
        @(negedge clk);
        load_val = v.spare | enc_nk(v.on, v.ok) | enc_mp(v.om, v.op);
        load_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_req = 1'b0;
        settle_cycles = 16'(v.settle);
        req_n = v.nn; req_k = v.nk; req_m = v.nm; req_plog = v.np;
        req_valid = 1'b1;
        rd_cyc = -1; nwr = 0; c1 = -1; c2 = -1; ack_cyc = -1; busy1 = 0;
        w1 = '0; w2 = '0;
        for (int cyc = 1; cyc < 400; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (cyc == 1) busy1 = int'(busy);
            if (chg_at == cyc) begin
                req_n = 6'd31; req_k = 3'd1; req_m = 3'd4; req_plog = 2'd3;
            end
            if (rd_en) rd_cyc = cyc;
            if (wr_en) begin
                if (nwr == 0) begin w1 = wr_data; c1 = cyc; end
                else begin w2 = wr_data; c2 = cyc; end
                nwr++;
            end
            if (req_ack) begin
                ack_cyc = cyc;
                req_valid = 1'b0;
                break;
            end
        end
    endtask

    // Compare the logged sequence with values derived from the requirements
    task automatic check_vec(input vec_t v);
        logic [31:0] init, exp1, exp2;
        int old_mp, new_mp, sp;
        bit divf, same;
        string ord;
        init   = v.spare | enc_nk(v.on, v.ok) | enc_mp(v.om, v.op);
        old_mp = int'(v.om) << v.op;
        new_mp = int'(v.nm) << v.np;
        divf   = new_mp > old_mp;
        same   = (v.on == v.nn) && (v.ok == v.nk) && (v.om == v.nm) && (v.op == v.np);
        sp     = (v.settle == 0) ? 1 : int'(v.settle);
        exp1   = divf ? ((init & ~MP_MASK) | enc_mp(v.nm, v.np))
                      : ((init & ~NK_MASK) | enc_nk(v.nn, v.nk));
        exp2   = v.spare | enc_nk(v.nn, v.nk) | enc_mp(v.nm, v.np);
        ord    = divf ? "R4 R3 R7 first write" : "R5 R3 R7 first write";
        chk(rd_cyc == 1, "R2 read cycle", 32'(rd_cyc), 32'd1);
        chk(busy1 == 1, "R1 busy after accept", 32'(busy1), 32'd1);
        if (same) begin
            chk(nwr == 0, "R9 write count", 32'(nwr), 32'd0);
            chk(ack_cyc == 2, "R9 ack cycle", 32'(ack_cyc), 32'd2);
            chk(reg_model == init, "R9 register kept", reg_model, init);
        end else begin
            chk(nwr == 2, "R6 write count", 32'(nwr), 32'd2);
            chk(w1 == exp1, ord, w1, exp1);
            chk(c1 == 2, "R4 R5 first write cycle", 32'(c1), 32'd2);
            chk(w2 == exp2, "R6 R7 second write", w2, exp2);
            chk(c2 - c1 == sp + 1, "R8 settle gap", 32'(c2 - c1), 32'(sp + 1));
            chk(ack_cyc == c2 + 1, "R10 ack after second write", 32'(ack_cyc), 32'(c2 + 1));
            chk(reg_model == exp2, "R6 final register", reg_model, exp2);
        end
        @(posedge clk);
        @(negedge clk);
        chk(!req_ack && !busy, "R10 ack single cycle", {30'd0, req_ack, busy}, 32'd0);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !req_ack && !rd_en && !wr_en, "R1 reset state",
            {28'd0, busy, req_ack, rd_en, wr_en}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i], 0);
            check_vec(VECS[i]);
        end

        // R10: request inputs changed mid-sequence must not alter the writes
        run_seq(VECS[0], 3);
        check_vec(VECS[0]);

        // R11: reset during the settle wait aborts cleanly
        v = VECS[1];
        v.settle = 8'd50;
        @(negedge clk);
        load_val = v.spare | enc_nk(v.on, v.ok) | enc_mp(v.om, v.op);
        load_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_req = 1'b0;
        settle_cycles = 16'd50;
        req_n = v.nn; req_k = v.nk; req_m = v.nm; req_plog = v.np;
        req_valid = 1'b1;
        repeat (5) begin @(posedge clk); @(negedge clk); end
        chk(busy && !wr_en, "R11 in wait before reset", {30'd0, busy, wr_en}, 32'd2);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!busy && !wr_en && !rd_en && !req_ack, "R11 idle after reset",
            {28'd0, busy, wr_en, rd_en, req_ack}, 32'd0);
        rst_n = 1'b1;
        run_seq(VECS[3], 0);
        chk(ack_cyc > 0, "R11 recovery ack", 32'(ack_cyc), 32'd1);
        check_vec(VECS[3]);

        summary();
        $finish;
    end
endmodule